// File: doc/BRIEF.md
# General-Purpose I/O Bank with Interrupt Summaries

This block provides a parameterised bank of general-purpose I/O lines, 32 by default, behind a small word-addressed register bus that has separate read and write strobes. Each line has its own output latch, direction bit, blink enable and input inversion bit. The pad side uses three plain vectors: the driven value, the per-line output enable and the sampled pad value.

Pad inputs pass through a two-flop synchroniser and then an inversion stage. The adjusted value serves as the level cause. Its low-to-high transitions are also captured in a sticky edge cause register, which software clears by writing zeros. The block gates level causes and edge causes with separate masks and merges them per line. It then ORs the lines in groups of eight to drive one registered summary interrupt per group.

Top module: `pio_bank`

## Requirements
- R1: After reset every line is an input (pad_oe all 0). The blink, inversion, edge cause, edge mask and level mask registers read 0, the direction register reads all ones, and irq is 0.
- R2: Direction bit 1 makes the line an input with pad_oe low. Direction bit 0 raises pad_oe and drives the output latch onto pad_out.
- R3: The word addresses are 0 output latch, 1 direction, 2 blink enable, 3 input inversion, 4 input value, 5 edge cause, 6 edge mask and 7 level mask. A register written at an address reads back the same value. The read data appears in the cycle after rd_en.
- R4: The input value word returns the pad value, delayed by a two-flop synchroniser, XOR the inversion bits.
- R5: A line whose level mask bit is 1 raises its group's irq while its input value bit is 1.
- R6: An edge cause bit sets when that line's input value goes from 0 to 1. Inversion 0 therefore catches rising pad edges and inversion 1 catches falling pad edges. The bit stays set after the pad returns.
- R7: A write to the edge cause word clears each bit written as 0 and keeps each bit written as 1. When a new edge arrives in the same cycle as its clear, the bit stays set.
- R8: A set edge cause bit raises its group's irq only while its edge mask bit is 1. irq[g] is the OR of lines 8g to 8g+7, registered one cycle, and irq is 0 whenever both masks are 0.
- R9: On an output line with blink enable set, pad_out is the latch value XOR a free-running square wave that toggles every BLINK_HALF clocks.
- R10: Writes to the input value word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| pad_in | input | 32 | Pad input values, asynchronous |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables, 1 drives |
| irq | output | 4 | Summary interrupts, one per group of eight lines |

## Verification
The hardest case to reach is a new edge that arrives in the same clock as a software clear of that same bit. The edge only becomes visible two synchroniser stages after the pad moves. The bench therefore changes the pad on a falling clock edge and counts two rising edges. It then places the clearing write in the one cycle where the edge is being captured, and checks that the bit survives while an older bit in the same write is cleared. Falling-edge capture needs the inversion bit set first, and setting it itself produces an edge. The bench clears that edge before it drives the pad.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    REG_OUT   = 3'd0,
    REG_DIR   = 3'd1,
    REG_BLINK = 3'd2,
    REG_POL   = 3'd3,
    REG_IN    = 3'd4,
    REG_CAUSE = 3'd5,
    REG_EMASK = 3'd6,
    REG_LMASK = 3'd7
  } pio_reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/pio_blink.sv
module pio_blink #(
  parameter int HALF = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
  parameter int N_LINES    = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] din,
  input  logic               cause_wr,
  input  logic [N_LINES-1:0] cause_wdata,
  input  logic [N_LINES-1:0] edge_mask,
  input  logic [N_LINES-1:0] lvl_mask,
  output logic [N_LINES-1:0] cause,
  output logic [N_LINES-1:0] rise,
  output logic [N_LINES/GROUP_SIZE-1:0] irq
);
  localparam int N_GROUPS = N_LINES / GROUP_SIZE;

  logic [N_LINES-1:0]  prev_q, cause_q, cause_d, line_act;
  logic [N_GROUPS-1:0] irq_q, irq_d;

  assign rise = din & ~prev_q;

  always_comb begin
    if (cause_wr) cause_d = (cause_q & cause_wdata) | rise;
    else          cause_d = cause_q | rise;
    line_act = (din & lvl_mask) | (cause_q & edge_mask);
  end

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign irq_d[g] = |line_act[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
      irq_q   <= '0;
    end else begin
      prev_q  <= din;
      cause_q <= cause_d;
      irq_q   <= irq_d;
    end
  end

  assign cause = cause_q;
  assign irq   = irq_q;
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int N_LINES    = 32,
  parameter int GROUP_SIZE = 8,
  parameter int BLINK_HALF = 1 << 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [2:0]                    addr,
  input  logic [N_LINES-1:0]            wr_data,
  output logic [N_LINES-1:0]            rd_data,
  input  logic [N_LINES-1:0]            pad_in,
  output logic [N_LINES-1:0]            pad_out,
  output logic [N_LINES-1:0]            pad_oe,
  output logic [N_LINES/GROUP_SIZE-1:0] irq
);
  localparam int N_GROUPS = N_LINES / GROUP_SIZE;

  logic rst_meta_q, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic [N_LINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q, rd_q;
  logic [N_LINES-1:0] out_d, dir_d, blink_d, pol_d, emask_d, lmask_d, rd_d;
  logic [N_LINES-1:0] pad_s, din_w, cause_w, rise_w;
  logic               phase_w, cause_wr;
  pio_reg_e           sel;

  assign sel      = pio_reg_e'(addr);
  assign cause_wr = wr_en && (sel == REG_CAUSE);

  pio_sync #(.WIDTH(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d(pad_in), .q(pad_s)
  );

  assign din_w = pad_s ^ pol_q;

  pio_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n_s), .phase(phase_w)
  );

  pio_irq #(.N_LINES(N_LINES), .GROUP_SIZE(GROUP_SIZE)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .din(din_w),
    .cause_wr(cause_wr), .cause_wdata(wr_data),
    .edge_mask(emask_q), .lvl_mask(lmask_q),
    .cause(cause_w), .rise(rise_w), .irq(irq)
  );

  always_comb begin
    out_d   = out_q;
    dir_d   = dir_q;
    blink_d = blink_q;
    pol_d   = pol_q;
    emask_d = emask_q;
    lmask_d = lmask_q;
    if (wr_en) begin
      case (sel)
        REG_OUT:   out_d   = wr_data;
        REG_DIR:   dir_d   = wr_data;
        REG_BLINK: blink_d = wr_data;
        REG_POL:   pol_d   = wr_data;
        REG_EMASK: emask_d = wr_data;
        REG_LMASK: lmask_d = wr_data;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      case (sel)
        REG_OUT:   rd_d = out_q;
        REG_DIR:   rd_d = dir_q;
        REG_BLINK: rd_d = blink_q;
        REG_POL:   rd_d = pol_q;
        REG_IN:    rd_d = din_w;
        REG_CAUSE: rd_d = cause_w;
        REG_EMASK: rd_d = emask_q;
        REG_LMASK: rd_d = lmask_q;
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
      rd_q    <= '0;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      blink_q <= blink_d;
      pol_q   <= pol_d;
      emask_q <= emask_d;
      lmask_q <= lmask_d;
      rd_q    <= rd_d;
    end
  end

  assign pad_oe  = ~dir_q;
  assign pad_out = out_q ^ (blink_q & {N_LINES{phase_w}});
  assign rd_data = rd_q;

  if (N_GROUPS * GROUP_SIZE != N_LINES) begin : g_bad_cfg
    initial $error("N_LINES must be a multiple of GROUP_SIZE");
  end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_pkg::*;
#(
  parameter int N_LINES    = 32,
  parameter int GROUP_SIZE = 8
) (
  input logic                          clk,
  input logic                          rst_n_s,
  input logic                          wr_en,
  input logic [2:0]                    addr,
  input logic [N_LINES-1:0]            wr_data,
  input logic [N_LINES-1:0]            pad_oe,
  input logic [N_LINES-1:0]            cause,
  input logic [N_LINES-1:0]            rise,
  input logic [N_LINES-1:0]            emask,
  input logic [N_LINES-1:0]            lmask,
  input logic [N_LINES/GROUP_SIZE-1:0] irq
);
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && addr == REG_DIR) |=> (pad_oe == ~$past(wr_data))); // R2

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(wr_en && addr == REG_CAUSE) |=> ((~cause & $past(cause)) == '0)); // R6

  AST_CLEAR_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && addr == REG_CAUSE) |=> ((~cause & $past(cause) & $past(wr_data)) == '0)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rise != '0) |=> ((cause & $past(rise)) == $past(rise))); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (emask == '0 && lmask == '0) |=> (irq == '0)); // R8
endmodule

bind pio_bank pio_bank_chk #(.N_LINES(N_LINES), .GROUP_SIZE(GROUP_SIZE)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .pad_oe(pad_oe), .cause(cause_w), .rise(rise_w), .emask(emask_q),
  .lmask(lmask_q), .irq(irq)
);

// File: tb/test_pio_bank.sv
`timescale 1ns/1ps
module test_pio_bank;
  localparam int N = 32;
  localparam int HALF = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [2:0]    addr;
  logic [N-1:0]  wr_data, rd_data, pad_in, pad_out, pad_oe;
  logic [3:0]    irq;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  pio_bank #(.N_LINES(N), .GROUP_SIZE(8), .BLINK_HALF(HALF)) i_pio_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 irq", {28'd0, irq}, '0);
    rd(3'd1, v); chk("R1 dir", v, '1);
    rd(3'd2, v); chk("R1 blink", v, '0);
    rd(3'd3, v); chk("R1 pol", v, '0);
    rd(3'd5, v); chk("R1 cause", v, '0);
    rd(3'd6, v); chk("R1 emask", v, '0);
    rd(3'd7, v); chk("R1 lmask", v, '0);
  endtask

  task automatic t_regs();
    logic [N-1:0] v;
    wr(3'd0, 32'h1234_5678); rd(3'd0, v); chk("R3 out readback", v, 32'h1234_5678);
    wr(3'd2, 32'h0000_00F0); rd(3'd2, v); chk("R3 blink readback", v, 32'h0000_00F0);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'hFFFF_0000); rd(3'd1, v); chk("R3 dir readback", v, 32'hFFFF_0000);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    chk("R2 pad_out low half", pad_out & 32'h0000_FFFF, 32'h0000_5678);
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R2 all inputs", pad_oe, '0);
  endtask

  task automatic t_datain();
    logic [N-1:0] v;
    pad_in = 32'h0000_00A5; cyc(4);
    rd(3'd4, v); chk("R4 datain", v, 32'h0000_00A5);
    wr(3'd3, 32'h0000_000F); rd(3'd3, v); chk("R3 pol readback", v, 32'h0000_000F);
    rd(3'd4, v); chk("R4 datain inverted", v, 32'h0000_00AA);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); chk("R10 datain readonly", v, 32'h0000_00AA);
    wr(3'd3, 32'h0); pad_in = '0; cyc(4);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_level();
    pad_in = 32'h0000_0200; cyc(4);
    wr(3'd7, 32'h0000_0200); cyc(2);
    chk("R5 level irq", {28'd0, irq}, 32'h2);
    wr(3'd3, 32'h0000_0200); cyc(2);
    chk("R5 level inverted off", {28'd0, irq}, 32'h0);
    wr(3'd7, 32'h0); wr(3'd3, 32'h0); pad_in = '0; cyc(4);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_edge_rise();
    logic [N-1:0] v;
    wr(3'd6, 32'h0002_0000);
    pad_in = 32'h0002_0000; cyc(5);
    rd(3'd5, v); chk("R6 rising cause", v, 32'h0002_0000);
    chk("R8 edge irq", {28'd0, irq}, 32'h4);
    pad_in = '0; cyc(5);
    rd(3'd5, v); chk("R6 cause sticky", v, 32'h0002_0000);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R7 write ones keeps", v, 32'h0002_0000);
    wr(3'd6, 32'h0); cyc(2);
    chk("R8 edge masked", {28'd0, irq}, 32'h0);
    wr(3'd6, 32'h0002_0000);
    wr(3'd5, 32'hFFFD_FFFF); cyc(2);
    rd(3'd5, v); chk("R7 write zero clears", v, 32'h0);
    chk("R8 irq drops", {28'd0, irq}, 32'h0);
    wr(3'd6, 32'h0);
  endtask

  task automatic t_edge_fall();
    logic [N-1:0] v;
    wr(3'd3, 32'h0010_0000); cyc(4);
    wr(3'd5, 32'h0);
    pad_in = 32'h0010_0000; cyc(5);
    rd(3'd5, v); chk("R6 no cause on rise when inverted", v, 32'h0);
    pad_in = '0; cyc(5);
    rd(3'd5, v); chk("R6 falling cause", v, 32'h0010_0000);
    wr(3'd3, 32'h0); cyc(4);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_race();
    logic [N-1:0] v;
    pad_in = 32'h0000_0008; cyc(5);
    pad_in = '0; cyc(4);
    rd(3'd5, v); chk("R6 old bit set", v, 32'h0000_0008);
    pad_in = 32'h0000_0001;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd5; wr_data = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd5, v); chk("R7 set wins over clear", v, 32'h0000_0001);
    pad_in = '0; cyc(4);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_groups();
    wr(3'd7, 32'hFFFF_FFFF);
    pad_in = 32'h8000_0000; cyc(5);
    chk("R8 group 3", {28'd0, irq}, 32'h8);
    pad_in = 32'h0000_0001; cyc(5);
    chk("R8 group 0", {28'd0, irq}, 32'h1);
    pad_in = 32'h0001_0100; cyc(5);
    chk("R8 groups 1 and 2", {28'd0, irq}, 32'h6);
    wr(3'd7, 32'h0); pad_in = '0; cyc(4);
    wr(3'd5, 32'h0);
  endtask

  task automatic t_blink();
    logic prev;
    int   toggles = 0;
    wr(3'd0, 32'h0000_0060);
    wr(3'd1, 32'hFFFF_FF9F);
    wr(3'd2, 32'h0000_0020);
    cyc(1);
    prev = pad_out[5];
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (pad_out[5] !== prev) toggles++;
      prev = pad_out[5];
      if (pad_out[6] !== 1'b1) begin
        errors++;
        $display("FAIL R9 non-blink line: actual %b expected 1", pad_out[6]);
      end
    end
    checks++;
    chk("R9 toggle count", 32'(toggles), 32'(16 / HALF));
    chk("R2 blink oe", pad_oe & 32'h60, 32'h60);
    wr(3'd2, 32'h0); wr(3'd1, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0; pad_in = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_regs();
    t_datain();
    t_level();
    t_edge_rise();
    t_edge_fall();
    t_race();
    t_groups();
    t_blink();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule